// File: doc/BRIEF.md
# Bidirectional GPIO Port Bank

This block holds five 8-bit general-purpose I/O ports behind a simple processor bus. The bus has an address, write data, combinational read data, and read and write strobes. Each port has a data latch and a per-pin direction register. A pin whose direction bit is 1 is driven from its latch. A pin whose direction bit is 0 floats, and its pad level is what software reads back. Pad levels pass through a two-stage synchronizer before they reach the read path or the wake-up logic.

Each pin also has a pull-up enable. Port 4 carries a key-on wake-up detector: each pin has an enable, and one register bit sets whether the active level is low or high. A detection is held as a sticky request until software clears it. Peripheral alternate functions are not built here. They reach the pads only through a per-pin override, which replaces the latch and direction with externally supplied values. Several pin positions do not exist: bit 0 of port 1 and bits 5 to 7 of port 3.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every latch, direction bit, pull-up enable, wake enable, polarity bit and the wake request are 0. pad_out, pad_oe, pad_pu and wake_irq are all 0, and a read of any address returns 0 while the pads are low.
- R2: A write to address 0x08+2·i (i = 0..4) loads port i's latch. With no override active, pad_out for port i shows the latch from the clock edge that performs the write.
- R3: A write to address 0x09+2·i loads port i's direction register. For each pin, bit value 1 sets pad_oe to 1 (output) and bit value 0 sets it to 0 (input).
- R4: A read of address 0x08+2·i returns the latch bit for every pin of port i whose direction bit is 1.
- R5: For pins whose direction bit is 0, that read returns the pad level. The level is sampled through two flops: a pad change set up before clock edge k is visible after edge k+1 and not after edge k.
- R6: A write to an input pin changes only its latch, and pad_oe stays 0. A later switch of that pin to output drives the stored value.
- R7: Direction registers are write-only. Reading addresses 0x09+2·i returns 0.
- R8: Port 1 bit 0 and port 3 bits 5..7 are unimplemented. They read as 0, ignore writes, and never assert pad_out, pad_oe or pad_pu.
- R9: Address 0x20+i holds port i's pull-up enables, and it can be read back. pad_pu is 1 only for a pin whose enable is 1 and which is not being driven.
- R10: Bit 0 of address 0x2F selects the wake polarity: 0 means active low and 1 means active high. Address 0x28 holds the per-pin wake enables for port 4.
- R11: When a synchronized port-4 pin is enabled for wake, has direction 0 and shows the active level, the wake request is set one edge later. The request drives wake_irq and stays set after the pin returns to the inactive level. Writing 1 to bit 0 of address 0x2E clears it, and bit 0 of a read at 0x2E returns it. Disabled pins and output pins never set it.
- R12: When alt_sel for a pin is 1, pad_out and pad_oe for that pin follow alt_out and alt_oe instead of the latch and direction. Read-back is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 40 | Pad levels, port i at bits 8i+7..8i |
| pad_out | output | 40 | Pad drive value |
| pad_oe | output | 40 | Pad output enable |
| pad_pu | output | 40 | Pad pull-up enable |
| alt_sel | input | 40 | Per-pin alternate-function override select |
| alt_out | input | 40 | Alternate drive value |
| alt_oe | input | 40 | Alternate output enable |
| wake_irq | output | 1 | Sticky key-on wake-up request |

## Verification
Every stored bit in this block reaches the ports within one edge. A corrupted latch or direction bit shows up on pad_out or pad_oe right after the writing edge, and in the read value in the same cycle it is requested. A wrong synchronizer depth shifts the moment a pad change becomes readable by one edge either way. The bench samples both sides of that edge. A wake request that fails to hold, fails to clear or sets from the wrong pin shows up on wake_irq within three edges of the pad change.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and the implemented-pin map for the GPIO port bank.
// Assumes 8-bit ports and a 6-bit register address space.
package gpio_bank_pkg;
    localparam int PORT_W     = 8;
    localparam int PORT_N     = 5;
    localparam int BUS_AW     = 6;
    localparam int DATA_BASE  = 8'h08;   // data i at DATA_BASE + 2*i
    localparam int DIR_BASE   = 8'h09;   // direction i at DIR_BASE + 2*i
    localparam int PULL_BASE  = 8'h20;   // pull-up enables i at PULL_BASE + i
    localparam int WAKE_EN_A  = 8'h28;
    localparam int WAKE_FLG_A = 8'h2E;
    localparam int POLAR_A    = 8'h2F;

    // Pins that physically exist for a given port number.
    function automatic logic [PORT_W-1:0] impl_mask(input int p);
        case (p)
            1:       impl_mask = 8'hFE;
            3:       impl_mask = 8'h1F;
            default: impl_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Multi-flop synchronizer for asynchronous pad levels.
// Assumes every bit is independent (no multi-bit coherence required).
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pad levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
// One GPIO port: data latch, direction and pull-up registers, read-back
// selection and alternate-function override. Bits outside IMPL are
// held at zero and never drive the pad.
module gpio_port #(
    parameter int             PW   = 8,
    parameter logic [PW-1:0]  IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_latch,
    input  logic          wr_dir,
    input  logic          wr_pull,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pin_sync,
    input  logic [PW-1:0] alt_sel,
    input  logic [PW-1:0] alt_out,
    input  logic [PW-1:0] alt_oe,
    output logic [PW-1:0] dir_q,
    output logic [PW-1:0] pull_q,
    output logic [PW-1:0] rd_val,
    output logic [PW-1:0] pad_out,
    output logic [PW-1:0] pad_oe,
    output logic [PW-1:0] pad_pu
);
    logic [PW-1:0] latch_q;

    // Data latch: loaded by bus writes, unimplemented bits stay 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (wr_latch) latch_q <= wdata & IMPL;
    end

    // Direction register: 1 = output, 0 = input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata & IMPL;
    end

    // Pull-up enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pull_q <= '0;
        else if (wr_pull) pull_q <= wdata & IMPL;
    end

    // Read-back: latch for outputs, synchronized pad for inputs.
    always_comb rd_val = ((dir_q & latch_q) | (~dir_q & pin_sync)) & IMPL;

    // Pad drive with per-pin alternate override.
    always_comb begin
        pad_out = ((alt_sel & alt_out) | (~alt_sel & latch_q)) & IMPL;
        pad_oe  = ((alt_sel & alt_oe)  | (~alt_sel & dir_q))   & IMPL;
        pad_pu  = pull_q & ~pad_oe & IMPL;
    end
endmodule

// File: rtl/gpio_wake.sv
// Key-on wake-up detector: sets a sticky request when any enabled input
// pin shows the selected active level. Set has priority over clear.
module gpio_wake #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pin_sync,
    input  logic [PW-1:0] dir_q,
    input  logic [PW-1:0] wake_en,
    input  logic          active_high,
    input  logic          clr,
    output logic          req_q
);
    logic [PW-1:0] active;
    logic          hit;

    // Qualify each pin by polarity, enable and input direction.
    always_comb begin
        active = active_high ? pin_sync : ~pin_sync;
        hit    = |(active & wake_en & ~dir_q);
    end

    // Sticky request flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   req_q <= 1'b0;
        else if (hit) req_q <= 1'b1;
        else if (clr) req_q <= 1'b0;
    end
endmodule

// File: rtl/gpio_bank.sv
// Register-mapped bank of GPIO ports with wake-up detection on one port.
// Assumes a single-cycle bus: writes act on the rising edge with bus_wr
// high, read data is combinational and zero when bus_rd is low.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPORTS    = PORT_N,
    parameter int PW        = PORT_W,
    parameter int ADDR_W    = BUS_AW,
    parameter int WAKE_PORT = 4,
    parameter int SYNC_N    = 2,
    localparam int TOT      = NPORTS * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [PW-1:0]     bus_rdata,
    input  logic [TOT-1:0]    pad_in,
    output logic [TOT-1:0]    pad_out,
    output logic [TOT-1:0]    pad_oe,
    output logic [TOT-1:0]    pad_pu,
    input  logic [TOT-1:0]    alt_sel,
    input  logic [TOT-1:0]    alt_out,
    input  logic [TOT-1:0]    alt_oe,
    output logic              wake_irq
);
    localparam logic [ADDR_W-1:0] A_WEN = ADDR_W'(WAKE_EN_A);
    localparam logic [ADDR_W-1:0] A_WFL = ADDR_W'(WAKE_FLG_A);
    localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(POLAR_A);

    logic [TOT-1:0] pad_sync;
    logic [PW-1:0]  rd_val [NPORTS];
    logic [PW-1:0]  dir_q  [NPORTS];
    logic [PW-1:0]  pull_q [NPORTS];
    logic [PW-1:0]  wake_en_q;
    logic           polar_q;
    logic           wake_clr;
    logic [PW-1:0]  rd_mux;

    gpio_sync #(.W(TOT), .STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DATA_BASE + 2*gi);
        localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_BASE + 2*gi);
        localparam logic [ADDR_W-1:0] A_PUL = ADDR_W'(PULL_BASE + gi);

        gpio_port #(.PW(PW), .IMPL(PW'(impl_mask(gi)))) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_latch (bus_wr && bus_addr == A_DAT),
            .wr_dir   (bus_wr && bus_addr == A_DIR),
            .wr_pull  (bus_wr && bus_addr == A_PUL),
            .wdata    (bus_wdata),
            .pin_sync (pad_sync[gi*PW +: PW]),
            .alt_sel  (alt_sel[gi*PW +: PW]),
            .alt_out  (alt_out[gi*PW +: PW]),
            .alt_oe   (alt_oe[gi*PW +: PW]),
            .dir_q    (dir_q[gi]),
            .pull_q   (pull_q[gi]),
            .rd_val   (rd_val[gi]),
            .pad_out  (pad_out[gi*PW +: PW]),
            .pad_oe   (pad_oe[gi*PW +: PW]),
            .pad_pu   (pad_pu[gi*PW +: PW])
        );
    end

    // Wake control registers: per-pin enables and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en_q <= '0;
            polar_q   <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_WEN) wake_en_q <= bus_wdata;
            if (bus_addr == A_POL) polar_q   <= bus_wdata[0];
        end
    end

    // Write-one-to-clear strobe for the wake request.
    always_comb wake_clr = bus_wr && bus_addr == A_WFL && bus_wdata[0];

    gpio_wake #(.PW(PW)) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_sync    (pad_sync[WAKE_PORT*PW +: PW]),
        .dir_q       (dir_q[WAKE_PORT]),
        .wake_en     (wake_en_q),
        .active_high (polar_q),
        .clr         (wake_clr),
        .req_q       (wake_irq)
    );

    // Read multiplexer; direction addresses fall through to zero.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (bus_addr == ADDR_W'(DATA_BASE + 2*i)) rd_mux = rd_val[i];
            if (bus_addr == ADDR_W'(PULL_BASE + i))   rd_mux = pull_q[i];
        end
        if (bus_addr == A_WEN) rd_mux = wake_en_q;
        if (bus_addr == A_WFL) rd_mux = PW'(wake_irq);
        if (bus_addr == A_POL) rd_mux = PW'(polar_q);
    end

    // Gate read data with the strobe.
    always_comb bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/gpio_bank_chk.sv
// Checker for gpio_bank: observes the bus and pad ports only.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPORTS = PORT_N,
    parameter int PW     = PORT_W,
    parameter int ADDR_W = BUS_AW,
    localparam int TOT   = NPORTS * PW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PW-1:0]     bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [PW-1:0]     bus_rdata,
    input logic [TOT-1:0]    alt_sel,
    input logic [TOT-1:0]    pad_out,
    input logic [TOT-1:0]    pad_oe,
    input logic [TOT-1:0]    pad_pu,
    input logic              wake_irq
);
    logic [TOT-1:0] absent;
    logic           is_dir_addr;

    // Collect the unimplemented pin positions and direction addresses.
    always_comb begin
        is_dir_addr = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            absent[i*PW +: PW] = ~PW'(impl_mask(i));
            if (bus_addr == ADDR_W'(DIR_BASE + 2*i)) is_dir_addr = 1'b1;
        end
    end

    // R8
    absent_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out | pad_pu) & absent) == '0);

    // R9
    pull_only_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R7
    dir_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_dir_addr) |-> bus_rdata == '0);

    // R2
    latch_to_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(DATA_BASE)) |=>
        ((pad_out[PW-1:0] & ~alt_sel[PW-1:0]) == ($past(bus_wdata) & ~alt_sel[PW-1:0])));

    // R11
    wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !(bus_wr && bus_addr == ADDR_W'(WAKE_FLG_A) && bus_wdata[0])) |=> wake_irq);

    // R8
    absent_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DATA_BASE + 2)) |-> bus_rdata[0] == 1'b0);
endmodule

bind gpio_bank gpio_bank_chk #(.NPORTS(NPORTS), .PW(PW), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .alt_sel   (alt_sel),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .wake_irq  (wake_irq)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int W  = 8;
    localparam int T  = NP * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_rdata;
    logic [T-1:0] pad_in = '0;
    logic [T-1:0] pad_out, pad_oe, pad_pu;
    logic [T-1:0] alt_sel = '0, alt_out = '0, alt_oe = '0;
    logic         wake_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .alt_sel(alt_sel),
        .alt_out(alt_out), .alt_oe(alt_oe), .wake_irq(wake_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] pins_of(input int p);
        if (p == 1) return 8'b1111_1110;
        if (p == 3) return 8'b0001_1111;
        return 8'hFF;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] rd;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1: reset state over every address and every output
        check("R1 pads", {pad_out[31:0], pad_oe[31:0]}, '0);
        check("R1 pu", {pad_pu, 23'd0, wake_irq}, '0);
        for (int a = 0; a < 64; a++) begin
            bus_read(6'(a), rd);
            check("R1 read", {56'(a), rd}, {56'(a), 8'h00});
        end

        // R2 R3 R4 R5 R8 R9: sweep every port with several patterns
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 6; k++) begin
                logic [W-1:0] lv, dv, pv, uv, m, ex;
                lv = 8'((k * 37 + p * 11) ^ 8'hA5);
                dv = 8'((k * 91 + p * 53) ^ 8'h3C);
                pv = 8'((k * 29 + p * 71) ^ 8'h5A);
                uv = 8'(~(k * 13 + p));
                m  = pins_of(p);
                pad_in[p*W +: W] = pv;
                bus_write(6'(8 + 2*p), lv);
                bus_write(6'(9 + 2*p), dv);
                bus_write(6'(32 + p), uv);
                settle(2);
                check("R2 pad_out", pad_out[p*W +: W], lv & m);
                check("R3 pad_oe", pad_oe[p*W +: W], dv & m);
                check("R9 pad_pu", pad_pu[p*W +: W], uv & ~dv & m);
                bus_read(6'(8 + 2*p), rd);
                ex = ((dv & lv) | (~dv & pv)) & m;
                check("R4 R5 R8 readback", rd, ex);
                bus_read(6'(32 + p), rd);
                check("R9 pull read", rd, uv & m);
                bus_read(6'(9 + 2*p), rd);
                check("R7 dir read", rd, 8'h00);
            end
            bus_write(6'(9 + 2*p), 8'h00);
            bus_write(6'(32 + p), 8'h00);
            pad_in[p*W +: W] = '0;
        end

        // R8: unimplemented positions ignore writes
        bus_write(6'h0E, 8'hFF);
        bus_write(6'h0F, 8'hFF);
        bus_write(6'h23, 8'hFF);
        settle(1);
        check("R8 p3 out", pad_out[31:29], 3'b000);
        check("R8 p3 oe", pad_oe[31:29], 3'b000);
        bus_read(6'h0E, rd);
        check("R8 p3 read", rd, 8'h1F);
        bus_write(6'h0B, 8'h01);
        bus_write(6'h0A, 8'h01);
        check("R8 p1 bit0", {pad_oe[8], pad_out[8]}, 2'b00);
        bus_write(6'h0F, 8'h00);

        // R5: two-flop latency on port 2
        bus_write(6'h0D, 8'h00);
        settle(2);
        @(negedge clk) pad_in[23:16] = 8'hC3;
        @(negedge clk);
        bus_addr = 6'h0C; bus_rd = 1'b1; #1;
        check("R5 after one edge", bus_rdata, 8'h00);
        bus_rd = 1'b0;
        @(negedge clk);
        bus_addr = 6'h0C; bus_rd = 1'b1; #1;
        check("R5 after two edges", bus_rdata, 8'hC3);
        bus_rd = 1'b0;

        // R6: write to input pin only touches latch
        bus_write(6'h09, 8'h00);
        bus_write(6'h08, 8'hAA);
        check("R6 still floating", pad_oe[7:0], 8'h00);
        bus_write(6'h09, 8'hFF);
        check("R6 drives stored", pad_out[7:0], 8'hAA);
        bus_read(6'h08, rd);
        check("R6 read latch", rd, 8'hAA);

        // R12: override changes pads, not read-back
        alt_sel[7:0] = 8'hFF; alt_out[7:0] = 8'h3C; alt_oe[7:0] = 8'h0F;
        alt_sel[8] = 1'b1; alt_out[8] = 1'b1; alt_oe[8] = 1'b1;
        settle(1);
        check("R12 alt out", pad_out[7:0], 8'h3C);
        check("R12 alt oe", pad_oe[7:0], 8'h0F);
        check("R12 absent pin", {pad_oe[8], pad_out[8]}, 2'b00);
        bus_read(6'h08, rd);
        check("R12 read unchanged", rd, 8'hAA);
        alt_sel = '0; alt_out = '0; alt_oe = '0;

        // R10 R11: wake detection, active low
        pad_in[39:32] = 8'hFF;
        bus_write(6'h11, 8'h00);
        bus_write(6'h28, 8'h01);
        bus_write(6'h2F, 8'h00);
        bus_read(6'h28, rd);
        check("R10 enable read", rd, 8'h01);
        settle(3);
        check("R11 idle", wake_irq, 1'b0);
        @(negedge clk) pad_in[32] = 1'b0;
        settle(2);
        check("R11 not yet", wake_irq, 1'b0);
        settle(1);
        check("R11 set", wake_irq, 1'b1);
        @(negedge clk) pad_in[32] = 1'b1;
        settle(4);
        check("R11 sticky", wake_irq, 1'b1);
        bus_read(6'h2E, rd);
        check("R11 flag read", rd, 8'h01);
        bus_write(6'h2E, 8'h01);
        check("R11 cleared", wake_irq, 1'b0);

        // R10: active high polarity
        bus_write(6'h2F, 8'h01);
        bus_read(6'h2F, rd);
        check("R10 polarity read", rd, 8'h01);
        settle(1);
        check("R10 high active", wake_irq, 1'b1);
        bus_write(6'h28, 8'h00);
        bus_write(6'h2E, 8'h01);
        settle(3);
        check("R11 disabled pins", wake_irq, 1'b0);

        // R11: output pins never wake
        bus_write(6'h11, 8'h02);
        bus_write(6'h28, 8'h02);
        settle(3);
        check("R11 output pin", wake_irq, 1'b0);
        bus_write(6'h11, 8'h00);
        settle(1);
        check("R11 input pin", wake_irq, 1'b1);

        finish_run();
    end
endmodule